// File: doc/BRIEF.md
# At-Speed Scan Test Sequencer

This block runs one transition-delay test on a muxed-D scan chain that wraps a small combinational circuit under test. After a start request it loads a first vector serially, launches a transition, captures the response with a functional edge, unloads the captured word serially, and compares it with an expected word. The chain is clocked only while a test runs. Between tests it holds its contents.

Two launch schemes are offered and a mode input picks one. In launch-on-shift the launch edge is one more shift with scan enable still high, so the second vector is the first moved by one cell. In launch-on-capture scan enable drops before the launch edge, so launch and capture are two back-to-back functional edges and the second vector is the circuit's own reply to the first. The circuit under test maps cell state `s` to `s[i] ^ s[(i+1) mod N]`. For example, an all-ones load gives an all-zeros response.

Top module: `scan_tsq_top`

## Requirements
- R1: After reset, `scan_en`, `scan_out`, `done` and `fail` are all low, and the chain cells are zero.
- R2: The clock edge that samples `start` high while idle begins a test. For the next N cycles `scan_en` is high and the bit on `scan_in` is shifted into cell 0. The first bit loaded ends in cell N-1.
- R3: When `mode` is 0 at start (launch-on-shift), the cycle after the load has `scan_en` high and shifts one more `scan_in` bit into cell 0. The cycle after that has `scan_en` low and loads the circuit response into the chain.
- R4: When `mode` is 1 at start (launch-on-capture), the two cycles after the load both have `scan_en` low. The chain takes the circuit response twice in a row.
- R5: The circuit under test produces bit i = cell i XOR cell ((i+1) mod N).
- R6: After capture, `scan_en` is high for N unload cycles. `scan_out` shows captured bit N-1 first, then N-2, down to bit 0.
- R7: `exp_vec` is sampled on the start edge. At `done`, `fail` is 1 exactly when the captured word differs from that sampled word in any bit.
- R8: `done` is high for exactly one cycle, 2N+2 clock edges after the edge that sampled `start`, and is low at all other times during a test.
- R9: `start`, `mode` and `exp_vec` changes made while a test is running have no effect on the sequence or the result.
- R10: `fail` keeps its value after `done` until the next test is accepted.
- R11: While idle the chain does not shift, so `scan_out` stays constant whatever `scan_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test when idle |
| mode | input | 1 | 0 = launch-on-shift, 1 = launch-on-capture |
| scan_in | input | 1 | Serial pattern bit into cell 0 |
| exp_vec | input | CHAIN_LEN | Expected captured word, sampled on start |
| scan_en | output | 1 | Scan enable applied to every cell |
| scan_out | output | 1 | Serial output from cell N-1 |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch result |

## Verification
The bench builds the block with CHAIN_LEN = 8. This gives a three-bit counter whose last value is its all-ones code, and it makes the 2N+2 done latency a distinct 18-edge figure. An eight-bit word is wide enough that random first vectors, random extra shift bits and single-bit differences in the expected word all reach the comparator, in both launch modes. Directed runs cover the all-ones load in each mode, a start pulse with changed mode and expected word in the middle of loading, and idle cycles while `scan_in` toggles.

// File: rtl/scan_tsq_pkg.sv
package scan_tsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_IN,
    ST_LAUNCH,
    ST_CAPTURE,
    ST_SHIFT_OUT,
    ST_DONE
  } seq_state_t;

  localparam logic MODE_LOS = 1'b0;
  localparam logic MODE_LOC = 1'b1;
endpackage

// File: rtl/scan_tsq_ctrl.sv
module scan_tsq_ctrl
  import scan_tsq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             scan_en,
  output logic             chain_clk_en,
  output logic             accept,
  output logic             cmp_en
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  logic mode_r;
  logic at_last;

  assign at_last = (cnt == LAST);
  assign accept  = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mode_r <= MODE_LOS;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            mode_r <= mode;
            state  <= ST_SHIFT_IN;
          end
        end
        ST_SHIFT_IN: begin
          cnt <= at_last ? '0 : cnt + 1'b1;
          if (at_last) state <= ST_LAUNCH;
        end
        ST_LAUNCH:  state <= ST_CAPTURE;
        ST_CAPTURE: begin
          cnt   <= '0;
          state <= ST_SHIFT_OUT;
        end
        ST_SHIFT_OUT: begin
          cnt <= at_last ? '0 : cnt + 1'b1;
          if (at_last) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scan_en      = 1'b0;
    chain_clk_en = 1'b0;
    cmp_en       = 1'b0;
    case (state)
      ST_SHIFT_IN:  begin scan_en = 1'b1; chain_clk_en = 1'b1; end
      ST_LAUNCH:    begin scan_en = (mode_r == MODE_LOS); chain_clk_en = 1'b1; end
      ST_CAPTURE:   begin scan_en = 1'b0; chain_clk_en = 1'b1; end
      ST_SHIFT_OUT: begin scan_en = 1'b1; chain_clk_en = 1'b1; cmp_en = 1'b1; end
      default:      ;
    endcase
  end
endmodule

// File: rtl/scan_tsq_cut.sv
module scan_tsq_cut #(
  parameter int CHAIN_LEN = 8
) (
  input  logic [CHAIN_LEN-1:0] cells,
  output logic [CHAIN_LEN-1:0] resp
);
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_xor
    assign resp[i] = cells[i] ^ cells[(i + 1) % CHAIN_LEN];
  end
endmodule

// File: rtl/scan_tsq_chain.sv
module scan_tsq_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  logic                 scan_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] cells
);
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    logic ser_d;
    logic mux_d;
    if (i == 0) begin : g_head
      assign ser_d = scan_in;
    end else begin : g_body
      assign ser_d = cells[i-1];
    end
    assign mux_d = scan_en ? ser_d : func_d[i];

    always_ff @(posedge clk) begin
      if (rst)         cells[i] <= 1'b0;
      else if (clk_en) cells[i] <= mux_d;
    end
  end
endmodule

// File: rtl/scan_tsq_cmp.sv
module scan_tsq_cmp #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = $clog2(CHAIN_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CHAIN_LEN-1:0] exp_vec,
  input  logic                 cmp_en,
  input  logic [CNT_W-1:0]     idx,
  input  logic                 obs,
  output logic                 fail
);
  logic [CHAIN_LEN-1:0] exp_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_r <= '0;
      fail  <= 1'b0;
    end else if (load) begin
      exp_r <= exp_vec;
      fail  <= 1'b0;
    end else if (cmp_en && (obs != exp_r[idx])) begin
      fail <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_tsq_top.sv
module scan_tsq_top
  import scan_tsq_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 mode,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] exp_vec,
  output logic                 scan_en,
  output logic                 scan_out,
  output logic                 done,
  output logic                 fail
);
  localparam int CNT_W = $clog2(CHAIN_LEN);

  seq_state_t           state;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     cmp_idx;
  logic                 chain_clk_en;
  logic                 accept;
  logic                 cmp_en;
  logic [CHAIN_LEN-1:0] cells;
  logic [CHAIN_LEN-1:0] resp;

  scan_tsq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .state(state), .cnt(cnt), .scan_en(scan_en),
    .chain_clk_en(chain_clk_en), .accept(accept), .cmp_en(cmp_en)
  );

  scan_tsq_cut #(.CHAIN_LEN(CHAIN_LEN)) cut_i (
    .cells(cells), .resp(resp)
  );

  scan_tsq_chain #(.CHAIN_LEN(CHAIN_LEN)) chain_i (
    .clk(clk), .rst(rst), .clk_en(chain_clk_en), .scan_en(scan_en),
    .scan_in(scan_in), .func_d(resp), .cells(cells)
  );

  assign cmp_idx = CNT_W'(CHAIN_LEN - 1) - cnt;

  scan_tsq_cmp #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) cmp_i (
    .clk(clk), .rst(rst), .load(accept), .exp_vec(exp_vec),
    .cmp_en(cmp_en), .idx(cmp_idx), .obs(cells[CHAIN_LEN-1]), .fail(fail)
  );

  assign scan_out = cells[CHAIN_LEN-1];
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/scan_tsq_chk.sv
module scan_tsq_chk
  import scan_tsq_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scan_in,
  input logic                 scan_en,
  input logic                 done,
  input logic                 fail,
  input seq_state_t           state,
  input logic                 chain_clk_en,
  input logic [CHAIN_LEN-1:0] cells,
  input logic [CHAIN_LEN-1:0] resp
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE)); // R9

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (chain_clk_en && !scan_en) |=> (cells == $past(resp))); // R4

  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    (chain_clk_en && scan_en) |=> (cells[0] == $past(scan_in))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !chain_clk_en |=> $stable(cells)); // R11

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && state != ST_IDLE) |=> fail); // R10
endmodule

bind scan_tsq_top scan_tsq_chk #(.CHAIN_LEN(CHAIN_LEN)) chk_i (
  .clk(clk), .rst(rst), .scan_in(scan_in), .scan_en(scan_en),
  .done(done), .fail(fail), .state(state), .chain_clk_en(chain_clk_en),
  .cells(cells), .resp(resp)
);

// File: tb/scan_tsq_top_tb_top.sv
module scan_tsq_top_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] exp_vec = '0;
  logic         scan_en, scan_out, done, fail;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scan_tsq_top #(.CHAIN_LEN(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .scan_in(scan_in),
    .exp_vec(exp_vec), .scan_en(scan_en), .scan_out(scan_out),
    .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [N-1:0] cut_f(input logic [N-1:0] s);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[i] ^ s[(i + 1) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] model_resp(input logic md, input logic [N-1:0] v1, input logic xb);
    logic [N-1:0] s;
    for (int j = 0; j < N; j++) s[j] = v1[N-1-j];
    if (md == 1'b0) s = {s[N-2:0], xb};
    else            s = cut_f(s);
    return cut_f(s);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_test(input logic md, input logic [N-1:0] v1, input logic xb,
                          input logic [N-1:0] ev, input bit poke);
    logic [N-1:0] r;
    logic         held;
    r = model_resp(md, v1, xb);
    mode = md; exp_vec = ev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      scan_in = v1[k];
      if (poke && k == 1) begin start = 1'b1; mode = ~md; exp_vec = ~ev; end
      if (poke && k == 3) start = 1'b0;
      chk(scan_en == 1'b1, "R2 load scan_en", scan_en, 1);
      chk(done == 1'b0, "R8 done low in load", done, 0);
      @(negedge clk);
    end
    start = 1'b0;
    scan_in = xb;
    chk(scan_en == (md == 1'b0), md ? "R4 launch scan_en" : "R3 launch scan_en", scan_en, md == 1'b0);
    @(negedge clk);
    scan_in = 1'($urandom);
    chk(scan_en == 1'b0, md ? "R4 capture scan_en" : "R3 capture scan_en", scan_en, 0);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      chk(scan_en == 1'b1, "R6 unload scan_en", scan_en, 1);
      chk(scan_out == r[N-1-k], poke ? "R9 R6 R5 unload bit" : "R6 R5 unload bit", scan_out, r[N-1-k]);
      chk(done == 1'b0, "R8 done low in unload", done, 0);
      scan_in = 1'($urandom);
      @(negedge clk);
    end
    chk(done == 1'b1, "R8 done at 2N+2", done, 1);
    chk(fail == (r != ev), poke ? "R9 R7 fail result" : "R7 fail result", fail, r != ev);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(fail == (r != ev), "R10 fail held", fail, r != ev);
    held = scan_out;
    for (int k = 0; k < 3; k++) begin
      scan_in = ~scan_in;
      @(negedge clk);
      chk(scan_out == held, "R11 idle hold", scan_out, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [N-1:0] v1;
    logic [N-1:0] ev;
    logic         md, xb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scan_en == 1'b0, "R1 reset scan_en", scan_en, 0);
    chk(scan_out == 1'b0, "R1 reset scan_out", scan_out, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(fail == 1'b0, "R1 reset fail", fail, 0);

    run_test(1'b0, '1, 1'b1, '0, 1'b0);           // R3 R5 all ones, passes
    run_test(1'b1, '1, 1'b0, '0, 1'b0);           // R4 R5 all ones, passes
    run_test(1'b1, '1, 1'b0, 8'h10, 1'b0);        // R7 one bit off, fails
    run_test(1'b0, 8'hA5, 1'b0, model_resp(1'b0, 8'hA5, 1'b0), 1'b0); // R7 clears fail
    run_test(1'b0, 8'h3C, 1'b1, model_resp(1'b0, 8'h3C, 1'b1), 1'b1); // R9 start poke
    run_test(1'b1, 8'h96, 1'b0, model_resp(1'b1, 8'h96, 1'b0), 1'b1); // R9 start poke

    for (int t = 0; t < 40; t++) begin
      md = 1'($urandom);
      v1 = N'($urandom);
      xb = 1'($urandom);
      ev = model_resp(md, v1, xb);
      if ($urandom_range(0, 1) == 1) ev = ev ^ (N'(1) << $urandom_range(0, N - 1));
      run_test(md, v1, xb, ev, 1'b0);
    end
    summary();
  end
endmodule